// File: doc/BRIEF.md
# Consumer Clock Source Mux-Divider

The block drives six peripheral consumer clocks. Each consumer has its own selector. The selector chooses one of seven candidate sources: the auxiliary PLL clock or one of six generator outputs. It then divides the chosen source by a small fixed ratio. Source code zero turns the consumer off, and a disabled consumer holds its clock low. One 32-bit control word configures all six consumers, with a 5-bit field for each. Software writes the word through a single write port and reads it back on a read port.

The whole block runs on one fast reference clock `clk`. The seven source waveforms arrive as levels that are synchronous to `clk` and slower than it. A source rising edge is a sample that is high after a sample that was low; one register holds the previous sample. Every consumer output is a register in the `clk` domain. It changes only at the points the requirements below define, so a change of source or ratio cannot produce a runt pulse.

A build-time switch selects between two divide tables. The two tables differ only in divide code 2: the standard table gives ratio 1 for it, and the alternative table gives ratio 3.

Top module: `clk_cons_mux`

## Requirements
- R1: While `rst` is high, every control field clears to zero. From the edge after `rst` is seen high, `cons_clk` is all low and `cfg_rdata` reads zero.
- R2: A `clk` edge with `cfg_wr` high stores `cfg_wdata[29:0]`. From the next cycle, `cfg_rdata` returns those bits unchanged, and bits 31:30 read as zero. Consumer i is configured by bits [5i+4:5i]. Within a field, bits [4:2] are the source code and bits [1:0] are the divide code.
- R3: Source code 0 disables the consumer, and its output is low from the second edge after the write. Code 1 selects `aux_src`. Codes 2 to 7 select `gen_src[0]` to `gen_src[5]`.
- R4: In the standard build (`RATIO3_VARIANT`=0), divide codes 0, 1, 2 and 3 give ratios 1, 4, 1 and 2.
- R5: In the alternative build (`RATIO3_VARIANT`=1), divide code 2 gives ratio 3, so codes 0 to 3 give ratios 1, 4, 3 and 2.
- R6: With ratio 1, the output copies the source level one `clk` cycle late. With ratios 2, 3 and 4, the output changes only at the edge after a source rising edge is sampled. The high time and low time are counted in source periods: 1 and 1 for ratio 2, 2 and 2 for ratio 4, and 1 and 2 for ratio 3.
- R7: A change of any bit of a consumer's field forces that output low at the second edge after the write. The output then stays low until the first source rising edge sampled after that. That rising edge starts a high phase, and counting restarts from the first phase.
- R8: A consumer whose field does not change keeps its waveform when other fields are rewritten.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| aux_src | input | 1 | Auxiliary PLL clock level, sampled by `clk` |
| gen_src | input | 6 | Generator output levels, sampled by `clk` |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to store |
| cfg_rdata | output | 32 | Stored control word |
| cons_clk | output | 6 | Consumer clock outputs, one per channel |

## Verification
Readback is due one edge after a write. A field change forces its output low at the second edge. A source rise sampled at an edge turns the output high at that same edge, so the new level can be seen in the next half cycle. The bench applies its stimulus at the falling edge and steps a behavioural model of these rules once per cycle, using the inputs the coming rising edge will sample. It then compares both builds' outputs and readback at the following falling edge. On top of that comparison, the bench measures pulse widths in whole `clk` cycles against the products of source half period and ratio. It also checks the forced-low cycle that follows a switch.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

   localparam int unsigned SEL_W  = 3;
   localparam int unsigned CODE_W = 2;
   localparam int unsigned PH_W   = 2;

   typedef struct packed {
      logic [SEL_W-1:0]  sel;
      logic [CODE_W-1:0] code;
   } ccm_field_t;

   typedef struct packed {
      ccm_field_t       act;
      logic             armed;
      logic [PH_W-1:0]  phase;
      logic             out;
   } ccm_state_t;

   // divide ratio for a code; three selects the alternative entry for code 2
   function automatic logic [2:0] ccm_ratio(input logic [CODE_W-1:0] code,
                                            input logic three);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd4;
         2'd2:    return three ? 3'd3 : 3'd1;
         default: return 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/ccm_cfg_reg.sv
module ccm_cfg_reg #(
   parameter int unsigned REG_W  = 32,
   parameter int unsigned USED_W = 30
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [REG_W-1:0]  wdata,
   output logic [USED_W-1:0] fields,
   output logic [REG_W-1:0]  rdata
);

   logic [USED_W-1:0] word_q;

   always_ff @(posedge clk) begin
      if (rst)
         word_q <= '0;
      else if (wr)
         word_q <= wdata[USED_W-1:0];
   end

   assign fields = word_q;
   assign rdata  = REG_W'(word_q);

   // R2
   readback_chk: assert property (@(posedge clk) disable iff (rst)
      wr |=> (rdata == REG_W'($past(wdata[USED_W-1:0]))));

endmodule

// File: rtl/ccm_rise_det.sv
module ccm_rise_det #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] lvl,
   output logic [N-1:0] rise
);

   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (rst)
         prev_q <= '0;
      else
         prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;

endmodule

// File: rtl/ccm_channel.sv
module ccm_channel
   import ccm_pkg::*;
#(
   parameter int unsigned N_SRC  = 7,
   parameter bit          RATIO3 = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  ccm_field_t       field,
   input  logic [N_SRC-1:0] lvl,
   input  logic [N_SRC-1:0] rise,
   output logic             clk_out
);

   logic       lvl_sel;
   logic       rise_sel;
   logic       src_valid;
   logic [2:0] ratio;
   logic [2:0] hi_len;
   logic [PH_W-1:0] ph_n;
   ccm_state_t st_q;
   ccm_state_t st_d;

   always_comb begin
      lvl_sel   = 1'b0;
      rise_sel  = 1'b0;
      src_valid = 1'b0;
      for (int k = 0; k < N_SRC; k++) begin
         if (field.sel == SEL_W'(k + 1)) begin
            lvl_sel   = lvl[k];
            rise_sel  = rise[k];
            src_valid = 1'b1;
         end
      end
   end

   generate
      if (RATIO3) begin : g_tbl_three
         assign ratio = ccm_ratio(field.code, 1'b1);
      end else begin : g_tbl_std
         assign ratio = ccm_ratio(field.code, 1'b0);
      end
   endgenerate

   assign hi_len = ratio >> 1;

   always_comb begin
      st_d = st_q;
      ph_n = '0;
      if (!src_valid || (field != st_q.act)) begin
         st_d.act   = field;
         st_d.armed = 1'b0;
         st_d.phase = '0;
         st_d.out   = 1'b0;
      end else if (rise_sel) begin
         if (st_q.armed && ({1'b0, st_q.phase} != (ratio - 3'd1)))
            ph_n = st_q.phase + 1'b1;
         st_d.armed = 1'b1;
         st_d.phase = ph_n;
         st_d.out   = (ratio == 3'd1) ? 1'b1 : ({1'b0, ph_n} < hi_len);
      end else if (st_q.armed && (ratio == 3'd1)) begin
         st_d.out = lvl_sel;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         st_q <= '0;
      else
         st_q <= st_d;
   end

   assign clk_out = st_q.out;

   // R3
   disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
      (field.sel == '0) |=> !clk_out);

   // R7
   switch_low_chk: assert property (@(posedge clk) disable iff (rst)
      (field != $past(field)) |=> !clk_out);

   // R6
   rise_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(clk_out) |-> $past(rise_sel));

   // R4
   phase_range_chk: assert property (@(posedge clk) disable iff (rst)
      (field == st_q.act) |-> ({1'b0, st_q.phase} < ratio));

endmodule

// File: rtl/clk_cons_mux.sv
module clk_cons_mux
   import ccm_pkg::*;
#(
   parameter int unsigned N_CH           = 6,
   parameter int unsigned N_GEN          = 6,
   parameter int unsigned REG_W          = 32,
   parameter int unsigned FIELD_W        = 5,
   parameter bit          RATIO3_VARIANT = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             aux_src,
   input  logic [N_GEN-1:0] gen_src,
   input  logic             cfg_wr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   output logic [N_CH-1:0]  cons_clk
);

   localparam int unsigned N_SRC  = N_GEN + 1;
   localparam int unsigned USED_W = N_CH * FIELD_W;

   generate
      if (FIELD_W != SEL_W + CODE_W) begin : g_bad_field
         $error("clk_cons_mux: FIELD_W must equal source plus divide code width");
      end
      if (USED_W > REG_W) begin : g_bad_reg
         $error("clk_cons_mux: fields do not fit in the control word");
      end
      if (N_SRC > (1 << SEL_W) - 1) begin : g_bad_src
         $error("clk_cons_mux: too many sources for the source code");
      end
   endgenerate

   logic [N_SRC-1:0]  src_lvl;
   logic [N_SRC-1:0]  src_rise;
   logic [USED_W-1:0] fields;

   assign src_lvl = {gen_src, aux_src};

   ccm_cfg_reg #(.REG_W(REG_W), .USED_W(USED_W)) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .wr     (cfg_wr),
      .wdata  (cfg_wdata),
      .fields (fields),
      .rdata  (cfg_rdata)
   );

   ccm_rise_det #(.N(N_SRC)) u_rise (
      .clk  (clk),
      .rst  (rst),
      .lvl  (src_lvl),
      .rise (src_rise)
   );

   generate
      for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
         ccm_channel #(.N_SRC(N_SRC), .RATIO3(RATIO3_VARIANT)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .field   (ccm_field_t'(fields[ch*FIELD_W +: FIELD_W])),
            .lvl     (src_lvl),
            .rise    (src_rise),
            .clk_out (cons_clk[ch])
         );
      end
   endgenerate

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> ((cons_clk == '0) && (cfg_rdata == '0)));

endmodule

// File: tb/clk_cons_mux_tb.sv
module clk_cons_mux_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH = 6;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [6:0]  src_v = '0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] rd_a, rd_b;
   logic [5:0]  cons_a, cons_b;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference state, [build][channel]
   logic [31:0] m_cfg [2];
   int  m_act [2][NCH];
   int  m_arm [2][NCH];
   int  m_ph  [2][NCH];
   int  m_out [2][NCH];
   logic [6:0] m_srcd;
   int  hp [7];
   int  scnt [7];

   always #(CLK_PERIOD/2) clk = ~clk;

   clk_cons_mux #(.RATIO3_VARIANT(1'b0)) u_dut (
      .clk(clk), .rst(rst), .aux_src(src_v[0]), .gen_src(src_v[6:1]),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_a), .cons_clk(cons_a));

   clk_cons_mux #(.RATIO3_VARIANT(1'b1)) u_dut_v3 (
      .clk(clk), .rst(rst), .aux_src(src_v[0]), .gen_src(src_v[6:1]),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_b), .cons_clk(cons_b));

   function automatic int ratio_of(int code, int v);
      case (code)
         0: return 1;
         1: return 4;
         2: return (v == 1) ? 3 : 1;
         default: return 2;
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_step();
      logic [6:0] rv;
      rv = src_v & ~m_srcd;
      for (int v = 0; v < 2; v++) begin
         for (int c = 0; c < NCH; c++) begin
            int f, sel, r;
            f   = int'((m_cfg[v] >> (5*c)) & 32'h1f);
            sel = f >> 2;
            r   = ratio_of(f & 3, v);
            if (rst) begin
               m_act[v][c] = 0; m_arm[v][c] = 0; m_ph[v][c] = 0; m_out[v][c] = 0;
            end else if (sel == 0 || f != m_act[v][c]) begin
               m_act[v][c] = f; m_arm[v][c] = 0; m_ph[v][c] = 0; m_out[v][c] = 0;
            end else if (rv[sel-1]) begin
               int p;
               p = (m_arm[v][c] != 0) ? ((m_ph[v][c] + 1) % r) : 0;
               m_arm[v][c] = 1;
               m_ph[v][c]  = p;
               m_out[v][c] = (r == 1) ? 1 : ((p < r/2) ? 1 : 0);
            end else if (m_arm[v][c] != 0 && r == 1) begin
               m_out[v][c] = src_v[sel-1] ? 1 : 0;
            end
         end
         if (rst)         m_cfg[v] = '0;
         else if (cfg_wr) m_cfg[v] = cfg_wdata & 32'h3fff_ffff;
      end
      m_srcd = rst ? '0 : src_v;
   endtask

   task automatic compare();
      for (int v = 0; v < 2; v++) begin
         logic [5:0] e;
         logic [5:0] a;
         logic [31:0] rd;
         for (int c = 0; c < NCH; c++) e[c] = (m_out[v][c] != 0);
         a  = (v == 0) ? cons_a : cons_b;
         rd = (v == 0) ? rd_a : rd_b;
         check(a == e, "R3 R4 R5 R6 R7 R8", $sformatf("build%0d cons_clk", v), a, e);
         check(rd == m_cfg[v], "R2", $sformatf("build%0d cfg_rdata", v), rd, m_cfg[v]);
      end
   endtask

   task automatic advance_sources();
      for (int k = 0; k < 7; k++) begin
         scnt[k]++;
         if (scnt[k] >= hp[k]) begin
            scnt[k] = 0;
            src_v[k] = ~src_v[k];
         end
      end
   endtask

   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
      advance_sources();
   endtask

   function automatic bit out_of(int v, int c);
      return (v == 0) ? cons_a[c] : cons_b[c];
   endfunction

   task automatic measure(input int v, input int c, input int hi, input int lo,
                          input string req);
      int h, l, g;
      h = 0; l = 0; g = 0;
      while (out_of(v, c) && g < 400) begin tick(); g++; end
      while (!out_of(v, c) && g < 400) begin tick(); g++; end
      while (out_of(v, c) && g < 400) begin tick(); h++; g++; end
      while (!out_of(v, c) && g < 400) begin tick(); l++; g++; end
      check(h == hi, req, $sformatf("build%0d ch%0d high cycles", v, c), h, hi);
      check(l == lo, req, $sformatf("build%0d ch%0d low cycles", v, c), l, lo);
   endtask

   task automatic write_cfg(input logic [31:0] d);
      cfg_wr = 1'b1; cfg_wdata = d;
      tick();
      cfg_wr = 1'b0;
   endtask

   function automatic logic [31:0] fld(int c, int sel, int code);
      return 32'((sel << 2) | code) << (5*c);
   endfunction

   initial begin
      logic [31:0] w;
      hp = '{3, 2, 4, 5, 3, 6, 7};
      for (int k = 0; k < 7; k++) scnt[k] = 0;
      m_srcd = '0;
      for (int v = 0; v < 2; v++) begin
         m_cfg[v] = '0;
         for (int c = 0; c < NCH; c++) begin
            m_act[v][c] = 0; m_arm[v][c] = 0; m_ph[v][c] = 0; m_out[v][c] = 0;
         end
      end

      // R1: reset state
      tick(); tick();
      check(cons_a == 6'd0 && cons_b == 6'd0, "R1", "cons_clk in reset",
            {cons_a, cons_b}, 0);
      check(rd_a == 32'd0 && rd_b == 32'd0, "R1", "readback in reset", rd_a, 0);
      rst = 1'b0;
      tick();

      // R2: upper bits dropped; R3: all disabled stay low
      write_cfg(32'hC000_0000);
      check(rd_a == 32'd0, "R2", "bits 31:30 read zero", rd_a, 0);
      for (int i = 0; i < 40; i++) begin
         tick();
         check(cons_a == 6'd0 && cons_b == 6'd0, "R3", "disabled stays low",
               {cons_a, cons_b}, 0);
      end

      // field map and divide table
      w = fld(0,1,0) | fld(1,1,1) | fld(2,1,2) | fld(3,1,3) | fld(4,2,0) | fld(5,7,0);
      write_cfg(w);
      check(rd_a == w && rd_b == w, "R2", "readback of fields", rd_a, w);
      measure(0, 0, 3, 3, "R4 R6 ratio1 aux");
      measure(0, 1, 12, 12, "R4 R6 ratio4");
      measure(0, 2, 3, 3, "R4 code2 ratio1");
      measure(1, 2, 6, 12, "R5 R6 ratio3");
      measure(0, 3, 6, 6, "R4 R6 ratio2");
      measure(0, 4, 2, 2, "R3 gen0");
      measure(0, 5, 7, 7, "R3 gen5");
      measure(1, 1, 12, 12, "R5 ratio4");

      // R7: switch channel 0 to gen1 ratio 2
      w = (w & ~fld(0,7,3)) | fld(0,3,3);
      write_cfg(w);
      tick();
      check(cons_a[0] == 1'b0 && cons_b[0] == 1'b0, "R7", "low after switch",
            {cons_a[0], cons_b[0]}, 0);
      measure(0, 0, 8, 8, "R7 R6 new source ratio2");
      measure(0, 1, 12, 12, "R8 untouched channel");

      // R3: disable channel 3 alone
      w = w & ~fld(3,7,3);
      write_cfg(w);
      tick();
      for (int i = 0; i < 30; i++) begin
         tick();
         check(cons_a[3] == 1'b0, "R3", "channel 3 disabled", cons_a[3], 0);
      end
      measure(0, 5, 7, 7, "R8 neighbour unaffected");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule